// File: doc/BRIEF.md
# Four-Level Translation Table Walker

This block resolves a 48-bit virtual address into a physical address using a 4KB translation granule. It reads 8-byte descriptors one at a time through a plain read request/response port. The walk starts from a root table page number that software programs before translation is turned on. It descends through up to four table levels, numbered 0 to 3. At each level a 9-bit slice of the virtual address selects the entry to read.

A descriptor above the last level either points to a finer table or maps a large region directly. The region is 1GB at level 1 and 2MB at level 2. At level 3 the descriptor maps a single 4KB page. When the walk succeeds, the block returns the physical address and the descriptor attributes, and it pulses a refill record for the translation cache. When the walk fails, it returns a fault code and the level at which the fault occurred. With translation switched off, a request completes as an identity mapping and no memory is touched. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: A request accepted while `xlat_en` is low completes on the next cycle with `done_pa` equal to the virtual address, no fault and no refill, and issues no memory read.
- R2: An enabled walk starts at level 0. Its first read address is `{tbl_root_pn, va[47:39], 3'b000}`.
- R3: A descriptor with bits [1:0] = 2'b11 at levels 0 to 2 is a table pointer. The next level's read address is `{desc[47:12], index, 3'b000}`, where the index is va[38:30], va[29:21] or va[20:12] for level 1, 2 or 3.
- R4: A descriptor with bits [1:0] = 2'b01 at level 1 ends the walk with `done_pa = {desc[47:30], va[29:0]}` and `done_level` = 1.
- R5: A descriptor with bits [1:0] = 2'b01 at level 2 ends the walk with `done_pa = {desc[47:21], va[20:0]}` and `done_level` = 2.
- R6: A descriptor with bits [1:0] = 2'b11 at level 3 ends the walk with `done_pa = {desc[47:12], va[11:0]}` and `done_level` = 3. On every successful walk, `done_attr` = `{desc[63:48], desc[11:2]}` of the final descriptor.
- R7: A descriptor with bit 0 clear ends the walk with `done_fault` = 1, `done_fault_kind` = 1 and `done_level` set to the level that was read.
- R8: A valid block descriptor at level 0 (bits [1:0] = 2'b01), or a level-3 descriptor with bit 1 clear, ends the walk with `done_fault` = 1, `done_fault_kind` = 2 and `done_level` set to that level.
- R9: A successful enabled walk pulses `refill_valid` in the same cycle as `done_valid`, with `refill_vpn` = va[47:12], `refill_ppn` = `done_pa[47:12]` and `refill_level` = the final level. A faulted walk does not pulse it.
- R10: At most one read is outstanding at a time. `busy` stays high from acceptance until the result cycle, and requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; low gives identity mapping |
| tbl_root_pn | input | 36 | Page number of the level-0 table |
| req_valid | input | 1 | Translation request, accepted when `busy` is low |
| req_va | input | 48 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| mem_rd_valid | output | 1 | One-cycle descriptor read request |
| mem_rd_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 64 | Descriptor read back |
| done_valid | output | 1 | One-cycle result strobe |
| done_pa | output | 48 | Translated physical address |
| done_attr | output | 26 | Upper and lower attribute bits of the final descriptor |
| done_fault | output | 1 | Walk ended in a fault |
| done_fault_kind | output | 2 | 0 none, 1 invalid entry, 2 malformed leaf |
| done_level | output | 2 | Level at which the walk ended |
| refill_valid | output | 1 | Translation cache refill strobe |
| refill_vpn | output | 36 | Virtual page number of the refill |
| refill_ppn | output | 36 | Physical page number of the refill |
| refill_level | output | 2 | Mapping level (1GB, 2MB or 4KB) of the refill |

## Verification
Two events can fall in one cycle. The final descriptor response can arrive while a new request is already waiting at the input, and the result can come out while that request is still held. The bench keeps a spurious request with a random address and a changing root asserted for the whole walk, so it coincides with every response, including the last. The result, the read count and the first read address must all match a bench model of the first address alone, and the waiting request must not be taken before `busy` drops. The bench also checks that the refill and result strobes arrive in the same cycle.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_INVALID  = 2'd1,
        FLT_BAD_FORM = 2'd2
    } fault_kind_e;

    typedef enum logic [1:0] {
        DK_TABLE    = 2'd0,
        DK_LEAF     = 2'd1,
        DK_INVALID  = 2'd2,
        DK_BAD_FORM = 2'd3
    } desc_kind_e;

endpackage

// File: rtl/pt_entry_addr.sv
`timescale 1ns/1ps
// Forms the byte address of the descriptor for the current level.
// The page offset width must equal index width plus entry shift.
module pt_entry_addr #(
    parameter int VA_W       = 48,
    parameter int PA_W       = 48,
    parameter int LEVELS     = 4,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int DESC_W     = 64
) (
    input  logic [VA_W-PAGE_SHIFT-1:0] vpn,
    input  logic [PA_W-PAGE_SHIFT-1:0] table_pn,
    input  logic [$clog2(LEVELS)-1:0]  level,
    output logic [PA_W-1:0]            entry_addr
);
    localparam int ENTRY_SHIFT = $clog2(DESC_W / 8);

    logic [IDX_W-1:0] slice [LEVELS];

    // Level 0 takes the top slice of the page number, the last level the bottom one.
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    always_comb begin
        entry_addr = {table_pn, slice[level], {ENTRY_SHIFT{1'b0}}};
    end

endmodule

// File: rtl/pt_desc_decode.sv
`timescale 1ns/1ps
// Classifies one descriptor at a given level and forms the leaf address.
module pt_desc_decode
    import pt_walker_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int LEVELS     = 4,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int DESC_W     = 64,
    localparam int OFF_MAX   = PAGE_SHIFT + IDX_W*(LEVELS-2),
    localparam int ATTR_W    = DESC_W - PA_W + PAGE_SHIFT - 2
) (
    input  logic [DESC_W-1:0]          desc,
    input  logic [$clog2(LEVELS)-1:0]  level,
    input  logic [OFF_MAX-1:0]         va_low,
    output desc_kind_e                 kind,
    output logic [PA_W-PAGE_SHIFT-1:0] next_pn,
    output logic [PA_W-1:0]            leaf_pa,
    output logic [ATTR_W-1:0]          attr
);
    localparam int LVL_W = $clog2(LEVELS);

    logic [PA_W-1:0] cand [LEVELS];

    // Each level keeps a wider slice of the virtual address as offset.
    for (genvar g = 0; g < LEVELS; g++) begin : g_leaf
        localparam int OFF = PAGE_SHIFT + IDX_W*(LEVELS-1-g);
        if (g == 0) begin : g_none
            assign cand[g] = '0;
        end else begin : g_map
            assign cand[g] = {desc[PA_W-1:OFF], va_low[OFF-1:0]};
        end
    end

    always_comb begin
        next_pn = desc[PA_W-1:PAGE_SHIFT];
        leaf_pa = cand[level];
        attr    = {desc[DESC_W-1:PA_W], desc[PAGE_SHIFT-1:2]};
        if (!desc[0]) begin
            kind = DK_INVALID;
        end else if (level == LVL_W'(LEVELS-1)) begin
            kind = desc[1] ? DK_LEAF : DK_BAD_FORM;
        end else if (level == '0) begin
            kind = desc[1] ? DK_TABLE : DK_BAD_FORM;
        end else begin
            kind = desc[1] ? DK_TABLE : DK_LEAF;
        end
    end

endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W       = 48,
    parameter int PA_W       = 48,
    parameter int LEVELS     = 4,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12,
    parameter int DESC_W     = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  xlat_en,
    input  logic [PA_W-PAGE_SHIFT-1:0]            tbl_root_pn,
    input  logic                                  req_valid,
    input  logic [VA_W-1:0]                       req_va,
    output logic                                  busy,
    output logic                                  mem_rd_valid,
    output logic [PA_W-1:0]                       mem_rd_addr,
    input  logic                                  mem_rsp_valid,
    input  logic [DESC_W-1:0]                     mem_rsp_data,
    output logic                                  done_valid,
    output logic [PA_W-1:0]                       done_pa,
    output logic [DESC_W-PA_W+PAGE_SHIFT-3:0]     done_attr,
    output logic                                  done_fault,
    output logic [1:0]                            done_fault_kind,
    output logic [$clog2(LEVELS)-1:0]             done_level,
    output logic                                  refill_valid,
    output logic [VA_W-PAGE_SHIFT-1:0]            refill_vpn,
    output logic [PA_W-PAGE_SHIFT-1:0]            refill_ppn,
    output logic [$clog2(LEVELS)-1:0]             refill_level
);
    localparam int LVL_W   = $clog2(LEVELS);
    localparam int PN_W    = PA_W - PAGE_SHIFT;
    localparam int VPN_W   = VA_W - PAGE_SHIFT;
    localparam int OFF_MAX = PAGE_SHIFT + IDX_W*(LEVELS-2);
    localparam int ATTR_W  = DESC_W - PA_W + PAGE_SHIFT - 2;

    typedef struct packed {
        walk_state_e       state;
        logic [LVL_W-1:0]  level;
        logic [VA_W-1:0]   va;
        logic [PN_W-1:0]   table_pn;
        logic              done;
        logic              refill;
        logic              fault;
        fault_kind_e       fkind;
        logic [LVL_W-1:0]  end_level;
        logic [PA_W-1:0]   pa;
        logic [ATTR_W-1:0] attr;
    } walk_s;

    walk_s walk_d, walk_q;

    desc_kind_e        dec_kind;
    logic [PN_W-1:0]   dec_next_pn;
    logic [PA_W-1:0]   dec_leaf_pa;
    logic [ATTR_W-1:0] dec_attr;

    pt_entry_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS),
        .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .DESC_W(DESC_W)
    ) entry_i (
        .vpn        (walk_q.va[VA_W-1:PAGE_SHIFT]),
        .table_pn   (walk_q.table_pn),
        .level      (walk_q.level),
        .entry_addr (mem_rd_addr)
    );

    pt_desc_decode #(
        .PA_W(PA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
        .PAGE_SHIFT(PAGE_SHIFT), .DESC_W(DESC_W)
    ) decode_i (
        .desc    (mem_rsp_data),
        .level   (walk_q.level),
        .va_low  (walk_q.va[OFF_MAX-1:0]),
        .kind    (dec_kind),
        .next_pn (dec_next_pn),
        .leaf_pa (dec_leaf_pa),
        .attr    (dec_attr)
    );

    always_comb begin
        walk_d        = walk_q;
        walk_d.done   = 1'b0;
        walk_d.refill = 1'b0;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    walk_d.va = req_va;
                    if (xlat_en) begin
                        walk_d.state    = ST_ISSUE;
                        walk_d.level    = '0;
                        walk_d.table_pn = tbl_root_pn;
                    end else begin
                        // Identity mapping, finished without any read.
                        walk_d.done      = 1'b1;
                        walk_d.fault     = 1'b0;
                        walk_d.fkind     = FLT_NONE;
                        walk_d.end_level = '0;
                        walk_d.pa        = PA_W'(req_va);
                        walk_d.attr      = '0;
                    end
                end
            end
            ST_ISSUE: begin
                walk_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (dec_kind)
                        DK_TABLE: begin
                            walk_d.state    = ST_ISSUE;
                            walk_d.table_pn = dec_next_pn;
                            walk_d.level    = walk_q.level + 1'b1;
                        end
                        DK_LEAF: begin
                            walk_d.state     = ST_IDLE;
                            walk_d.done      = 1'b1;
                            walk_d.refill    = 1'b1;
                            walk_d.fault     = 1'b0;
                            walk_d.fkind     = FLT_NONE;
                            walk_d.end_level = walk_q.level;
                            walk_d.pa        = dec_leaf_pa;
                            walk_d.attr      = dec_attr;
                        end
                        default: begin
                            walk_d.state     = ST_IDLE;
                            walk_d.done      = 1'b1;
                            walk_d.fault     = 1'b1;
                            walk_d.fkind     = (dec_kind == DK_INVALID) ? FLT_INVALID : FLT_BAD_FORM;
                            walk_d.end_level = walk_q.level;
                            walk_d.pa        = '0;
                            walk_d.attr      = '0;
                        end
                    endcase
                end
            end
            default: begin
                walk_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign busy            = (walk_q.state != ST_IDLE);
    assign mem_rd_valid    = (walk_q.state == ST_ISSUE);
    assign done_valid      = walk_q.done;
    assign done_pa         = walk_q.pa;
    assign done_attr       = walk_q.attr;
    assign done_fault      = walk_q.fault;
    assign done_fault_kind = walk_q.fkind;
    assign done_level      = walk_q.end_level;
    assign refill_valid    = walk_q.refill;
    assign refill_vpn      = walk_q.va[VA_W-1:PAGE_SHIFT];
    assign refill_ppn      = walk_q.pa[PA_W-1:PAGE_SHIFT];
    assign refill_level    = walk_q.end_level;

endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk #(
    parameter int VA_W       = 48,
    parameter int PA_W       = 48,
    parameter int IDX_W      = 9,
    parameter int PAGE_SHIFT = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       xlat_en,
    input logic [PA_W-PAGE_SHIFT-1:0] tbl_root_pn,
    input logic                       req_valid,
    input logic [VA_W-1:0]            req_va,
    input logic                       busy,
    input logic                       mem_rd_valid,
    input logic [PA_W-1:0]            mem_rd_addr,
    input logic                       mem_rsp_valid,
    input logic                       done_valid,
    input logic [PA_W-1:0]            done_pa,
    input logic                       done_fault,
    input logic [1:0]                 done_fault_kind,
    input logic                       refill_valid
);
    localparam int ENTRY_SHIFT = PAGE_SHIFT - IDX_W;

    logic            rd_pending;
    logic [VA_W-1:0] va_taken;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending <= 1'b0;
            va_taken   <= '0;
        end else begin
            if (mem_rd_valid) begin
                rd_pending <= 1'b1;
            end else if (mem_rsp_valid) begin
                rd_pending <= 1'b0;
            end
            if (req_valid && !busy) begin
                va_taken <= req_va;
            end
        end
    end

    AST_BYPASS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !xlat_en) |=> (!mem_rd_valid && done_valid && !done_fault && !refill_valid && done_pa == PA_W'($past(req_va)))); // R1

    AST_ROOT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && xlat_en) |=> (mem_rd_valid && mem_rd_addr == {$past(tbl_root_pn), $past(req_va[VA_W-1 -: IDX_W]), {ENTRY_SHIFT{1'b0}}})); // R2

    AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (done_pa[PAGE_SHIFT-1:0] == va_taken[PAGE_SHIFT-1:0])); // R6

    AST_FAULT_CODED: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_fault == (done_fault_kind != 2'd0))); // R7

    AST_REFILL_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> (done_valid && !done_fault)); // R9

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !rd_pending); // R10

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rsp_valid) |=> busy); // R10

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .xlat_en         (xlat_en),
    .tbl_root_pn     (tbl_root_pn),
    .req_valid       (req_valid),
    .req_va          (req_va),
    .busy            (busy),
    .mem_rd_valid    (mem_rd_valid),
    .mem_rd_addr     (mem_rd_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .done_valid      (done_valid),
    .done_pa         (done_pa),
    .done_fault      (done_fault),
    .done_fault_kind (done_fault_kind),
    .refill_valid    (refill_valid)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xlat_en;
    logic [35:0] tbl_root_pn;
    logic        req_valid;
    logic [47:0] req_va;
    logic        busy;
    logic        mem_rd_valid;
    logic [47:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done_valid;
    logic [47:0] done_pa;
    logic [25:0] done_attr;
    logic        done_fault;
    logic [1:0]  done_fault_kind;
    logic [1:0]  done_level;
    logic        refill_valid;
    logic [35:0] refill_vpn;
    logic [35:0] refill_ppn;
    logic [1:0]  refill_level;

    always #10 clk = ~clk;

    pt_walker dut_i (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_root_pn(tbl_root_pn),
        .req_valid(req_valid), .req_va(req_va), .busy(busy),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_pa(done_pa), .done_attr(done_attr),
        .done_fault(done_fault), .done_fault_kind(done_fault_kind), .done_level(done_level),
        .refill_valid(refill_valid), .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
        .refill_level(refill_level)
    );

    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;
    logic [63:0] tmem [logic [47:0]];
    logic [35:0] next_pn = 36'h0_0010_0000;
    int          rd_count;
    logic [47:0] rd_first;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rand64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [47:0] entry(input logic [35:0] pn, input logic [47:0] va, input int lvl);
        return {pn, va[47-9*lvl -: 9], 3'b000};
    endfunction

    function automatic logic [63:0] mem_read(input logic [47:0] a);
        return tmem.exists(a) ? tmem[a] : 64'h0;
    endfunction

    // Independent model of the walk, written from the requirements.
    task automatic ref_walk(input logic [47:0] va, input logic [35:0] root,
                            output logic [47:0] pa, output logic [25:0] attr,
                            output logic fault, output logic [1:0] kind,
                            output logic [1:0] lvl_o, output int reads);
        logic [35:0] pn = root;
        logic [63:0] d;
        logic [47:0] mask;
        pa = '0; attr = '0; fault = 1'b0; kind = 2'd0; lvl_o = 2'd0; reads = 0;
        for (int lvl = 0; lvl < 4; lvl++) begin
            d = mem_read(entry(pn, va, lvl));
            reads++;
            lvl_o = 2'(lvl);
            if (!d[0]) begin
                fault = 1'b1; kind = 2'd1; return;
            end
            if ((lvl == 0 || lvl == 3) && !d[1]) begin
                fault = 1'b1; kind = 2'd2; return;
            end
            if (d[1] && lvl < 3) begin
                pn = d[47:12];
            end else begin
                mask = (48'd1 << (12 + 9*(3-lvl))) - 48'd1;
                pa   = (d[47:0] & ~mask) | (va & mask);
                attr = {d[63:48], d[11:2]};
                return;
            end
        end
    endtask

    // scen: 0 L1 block, 1 L2 block, 2 L3 page, 3 invalid, 4 L0 block, 5 L3 malformed
    task automatic build(input logic [47:0] va, input int scen, output logic [35:0] root);
        logic [35:0] cur;
        logic [35:0] nxt;
        logic [63:0] r;
        int stop;
        root = next_pn; next_pn++;
        cur = root;
        case (scen)
            0: stop = 1;
            1: stop = 2;
            2: stop = 3;
            3: stop = int'($urandom % 4);
            4: stop = 0;
            default: stop = 3;
        endcase
        for (int lvl = 0; lvl < stop; lvl++) begin
            nxt = next_pn; next_pn++;
            r = rand64();
            tmem[entry(cur, va, lvl)] = {r[63:48], nxt, r[11:2], 2'b11};
            cur = nxt;
        end
        r = rand64();
        case (scen)
            0, 1:    tmem[entry(cur, va, stop)] = {r[63:2], 2'b01};
            2:       tmem[entry(cur, va, stop)] = {r[63:2], 2'b11};
            3:       tmem[entry(cur, va, stop)] = {r[63:1], 1'b0};
            default: tmem[entry(cur, va, stop)] = {r[63:2], 2'b01};
        endcase
    endtask

    // Memory responder: 1 to 3 cycles after each read.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        rd_count      = 0;
        rd_first      = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = rand64();
            if (mem_rd_valid) begin
                logic [47:0] a;
                a = mem_rd_addr;
                rd_count++;
                if (rd_count == 1) rd_first = a;
                repeat (1 + int'($urandom % 3)) @(negedge clk);
                mem_rsp_data  = mem_read(a);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    task automatic run_trial(input logic [47:0] va, input logic [35:0] root,
                             input bit en, input string tag);
        logic [47:0] e_pa;
        logic [25:0] e_attr;
        logic        e_fault;
        logic [1:0]  e_kind;
        logic [1:0]  e_lvl;
        int          e_reads;
        int          cyc;
        if (en) begin
            ref_walk(va, root, e_pa, e_attr, e_fault, e_kind, e_lvl, e_reads);
        end else begin
            e_pa = va; e_attr = '0; e_fault = 1'b0; e_kind = 2'd0; e_lvl = 2'd0; e_reads = 0;
        end
        @(negedge clk);
        rd_count = 0;
        xlat_en = en; tbl_root_pn = root; req_valid = 1'b1; req_va = va;
        @(negedge clk);
        cyc = 0;
        // R10: hold a spurious request with junk address and root while busy
        while (!done_valid && cyc < 200) begin
            if (busy) begin
                req_valid   = 1'b1;
                req_va      = rand64()[47:0];
                tbl_root_pn = rand64()[35:0];
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(done_valid, "R10", "result strobe", {63'd0, done_valid}, 64'd1);
        check(!busy, "R10", "busy low at result", {63'd0, busy}, 64'd0);
        check(done_fault == e_fault && done_fault_kind == e_kind, tag, "fault/kind",
              {62'd0, done_fault, done_fault_kind}, {62'd0, e_fault, e_kind});
        if (!e_fault) begin
            check(done_pa == e_pa, tag, "physical address", {16'd0, done_pa}, {16'd0, e_pa});
        end
        if (en) begin
            check(done_level == e_lvl, tag, "end level", {62'd0, done_level}, {62'd0, e_lvl});
            check(rd_count == e_reads, "R3", "read count", 64'(rd_count), 64'(e_reads));
            check(rd_first == {root, va[47:39], 3'b000}, "R2", "first read address",
                  {16'd0, rd_first}, {16'd0, root, va[47:39], 3'b000});
            if (!e_fault) begin
                check(done_attr == e_attr, "R6", "attributes", {38'd0, done_attr}, {38'd0, e_attr});
            end
        end else begin
            check(rd_count == 0, "R1", "no read when disabled", 64'(rd_count), 64'd0);
        end
        check(refill_valid == (en && !e_fault), "R9", "refill strobe",
              {63'd0, refill_valid}, {63'd0, en && !e_fault});
        if (en && !e_fault) begin
            check(refill_vpn == va[47:12] && refill_ppn == e_pa[47:12] && refill_level == e_lvl,
                  "R9", "refill record", {refill_vpn, refill_level, 26'd0},
                  {va[47:12], e_lvl, 26'd0});
        end
        // No stray second result after the walk
        @(negedge clk);
        check(!done_valid && !busy, "R10", "quiet after result",
              {62'd0, done_valid, busy}, 64'd0);
    endtask

    function automatic string scen_tag(input int scen);
        case (scen)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic scen_trial(input logic [47:0] va, input int scen);
        logic [35:0] root;
        build(va, scen, root);
        run_trial(va, root, 1'b1, scen_tag(scen));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; xlat_en = 1'b0; tbl_root_pn = '0; req_valid = 1'b0; req_va = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_rd_valid && !done_valid && !refill_valid, "R10", "reset state",
              {60'd0, busy, mem_rd_valid, done_valid, refill_valid}, 64'd0);

        // Directed corners: every scenario at address extremes
        for (int s = 0; s < 6; s++) begin
            scen_trial(48'h0, s);
            scen_trial(48'hFFFF_FFFF_FFFF, s);
        end
        // R1: translation disabled
        run_trial(48'h1234_5678_9ABC, 36'h0_0000_0777, 1'b0, "R1");
        run_trial(48'hFFFF_FFFF_FFFF, 36'h0, 1'b0, "R1");
        // R7: invalid at each level in turn comes from random stop choice; repeat a few
        for (int i = 0; i < 8; i++) scen_trial(rand64()[47:0], 3);

        // Random mix
        for (int i = 0; i < 180; i++) begin
            if ($urandom % 10 == 0) begin
                run_trial(rand64()[47:0], rand64()[35:0], 1'b0, "R1");
            end else begin
                scen_trial(rand64()[47:0], int'($urandom % 6));
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule